// File: doc/BRIEF.md
# Frame-Size-Adaptive Transmit/Receive FIFO Pair

This block holds the two data queues of a serial-port controller. One queue carries words from the processor toward the shift engine (transmit); the other carries words that the shift engine captured back toward the processor (receive). Each queue sits on its own 32-entry storage array. How many of those entries may be used depends on the configuration. With the deep-queue enable low, both queues hold 4 words. With it high, the limit follows the programmed frame width: narrow frames get all 32 entries, medium frames get 16 and wide frames get 8.

The block keeps the frame-width register and checks writes to it. It stores each accepted word, refuses writes once a queue is at its limit, and records a sticky overflow when a received word is lost. It publishes empty, empty-next, full-next and full flags for both queues in one status word. Each queue also has its own single-cycle flush.

The occupancy of each queue is tracked by a state machine with five states:
- `OCC_EMPTY`: no entries.
- `OCC_LAST`: one entry.
- `OCC_MID`: between the two ends.
- `OCC_NEAR`: one below the limit.
- `OCC_FULL`: at or above the limit.

Every cycle the next state is chosen from the next occupancy and the next limit. A flush always moves to `OCC_EMPTY`. Because the limit can shrink at run time, the machine can move straight from `OCC_MID` to `OCC_FULL` without any push.

Top module: `fsa_fifo_pair`

## Requirements
- R1: After reset both queues are empty, the status word reads 0x440 (bit 6 and bit 10 set), the frame width reads 4, the usable depth is 4, and both read-data outputs read 0.
- R2: While `big_fifo_en` is low, the usable depth of both queues is 4, whatever the frame width.
- R3: While `big_fifo_en` is high, the usable depth is 32 for frame widths 0 to 8, 16 for widths 9 to 16, and 8 for widths 17 to 32. A change to the enable or to the width takes effect on the cycle after it is applied, including when the queue already holds more entries than the new limit.
- R4: A frame-width write of a value above 32 is rejected and `fsz_q` keeps its old value. A write of 32 or less is stored.
- R5: A push into a queue that holds the usable depth or more, with no pop in the same cycle, is dropped: the occupancy and the stored data do not change.
- R6: Status bits are rx full 4, rx full-next 5, rx empty 6, rx empty-next 7, tx full 8, tx full-next 9, tx empty 10 and tx empty-next 11. Full means occupancy at or above the depth. Full-next means occupancy equal to depth minus one. Empty means zero entries. Empty-next means exactly one entry. All other bits of the status word are 0, except bit 2 (see R7).
- R7: A dropped receive push sets the overflow flag, status bit 2. The flag stays set until any receive pop or a receive flush.
- R8: A pop from an empty queue leaves its state unchanged, and that queue's read data reads 0. A receive pop clears the overflow flag even when the queue is empty.
- R9: Words leave each queue in the order they were accepted, including when the storage pointers wrap past entry 31.
- R10: A flush empties its queue on the next cycle and clears the receive overflow. A flush takes priority over a push or pop in the same cycle.
- R11: A push and a pop in the same cycle on a full queue are both accepted, and the occupancy stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_fifo_en | input | 1 | Deep-queue enable |
| fsz_wr | input | 1 | Frame-width register write strobe |
| fsz_wdata | input | 6 | Frame-width write value |
| fsz_q | output | 6 | Current frame width |
| tx_push | input | 1 | Processor push into the transmit queue |
| tx_wdata | input | DATA_W | Transmit push data |
| tx_pop | input | 1 | Engine pop from the transmit queue |
| tx_rdata | output | DATA_W | Transmit head word (0 when empty) |
| tx_flush | input | 1 | Transmit queue flush |
| rx_push | input | 1 | Engine push into the receive queue |
| rx_wdata | input | DATA_W | Receive push data |
| rx_pop | input | 1 | Processor pop from the receive queue |
| rx_rdata | output | DATA_W | Receive head word (0 when empty) |
| rx_flush | input | 1 | Receive queue flush |
| stat_word | output | 12 | Status flags (positions in R6, R7) |

## Verification
Each strobe is sampled on the edge where it is high, and the registered flags change on that same edge, so every status result is due one edge after its stimulus. A configuration change also reaches the depth on that edge. The head word is shown combinationally from the stored state, so it is checked before the pop that removes it. The bench drives inputs and samples outputs 1 ns after each rising edge. It compares the status word after every single edge of a sweep over both enable settings and every legal frame width, with the expected flags worked out from a simple occupancy count.

// File: rtl/fsa_pkg.sv
package fsa_pkg;

    typedef enum logic [2:0] {
        OCC_EMPTY = 3'd0,
        OCC_LAST  = 3'd1,
        OCC_MID   = 3'd2,
        OCC_NEAR  = 3'd3,
        OCC_FULL  = 3'd4
    } occ_state_t;

    localparam int STAT_W         = 12;
    localparam int STAT_RX_OVF    = 2;
    localparam int STAT_RX_FULL   = 4;
    localparam int STAT_RX_FNXT   = 5;
    localparam int STAT_RX_EMPTY  = 6;
    localparam int STAT_RX_ENXT   = 7;
    localparam int STAT_TX_FULL   = 8;
    localparam int STAT_TX_FNXT   = 9;
    localparam int STAT_TX_EMPTY  = 10;
    localparam int STAT_TX_ENXT   = 11;

endpackage

// File: rtl/fsa_depth_sel.sv
module fsa_depth_sel #(
    parameter int MEM_DEPTH    = 32,
    parameter int SMALL_DEPTH  = 4,
    parameter int MID_DEPTH    = 16,
    parameter int WIDE_DEPTH   = 8,
    parameter int NARROW_FRAME = 8,
    parameter int MEDIUM_FRAME = 16,
    parameter int FSZ_W        = 6,
    parameter int FSZ_MAX      = 32,
    parameter int FSZ_RST      = 4,
    localparam int CW          = $clog2(MEM_DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             big_en_i,
    input  logic             fsz_wr_i,
    input  logic [FSZ_W-1:0] fsz_wdata_i,
    output logic [FSZ_W-1:0] fsz_o,
    output logic [CW-1:0]    depth_o,
    output logic [CW-1:0]    depth_nxt_o
);

    logic             big_q;
    logic [FSZ_W-1:0] fsz_q;
    logic [FSZ_W-1:0] fsz_nxt;
    logic             wr_legal;

    function automatic logic [CW-1:0] depth_of(input logic big, input logic [FSZ_W-1:0] f);
        if (!big)
            return CW'(SMALL_DEPTH);
        else if (f <= FSZ_W'(NARROW_FRAME))
            return CW'(MEM_DEPTH);
        else if (f <= FSZ_W'(MEDIUM_FRAME))
            return CW'(MID_DEPTH);
        else
            return CW'(WIDE_DEPTH);
    endfunction

    assign wr_legal = fsz_wr_i && (fsz_wdata_i <= FSZ_W'(FSZ_MAX));
    assign fsz_nxt  = wr_legal ? fsz_wdata_i : fsz_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            big_q <= 1'b0;
            fsz_q <= FSZ_W'(FSZ_RST);
        end else begin
            big_q <= big_en_i;
            fsz_q <= fsz_nxt;
        end
    end

    assign fsz_o       = fsz_q;
    assign depth_o     = depth_of(big_q, fsz_q);
    assign depth_nxt_o = depth_of(big_en_i, fsz_nxt);

    // R4: an out-of-range width never lands in the register
    p_fsz_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fsz_wr_i && (fsz_wdata_i > FSZ_W'(FSZ_MAX))) |=> $stable(fsz_q));

    p_fsz_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fsz_q <= FSZ_W'(FSZ_MAX));

    // R2: deep-queue enable low pins the limit at the small depth
    p_small_depth_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !big_en_i |=> (depth_o == CW'(SMALL_DEPTH)));

endmodule

// File: rtl/fsa_fifo_chan.sv
module fsa_fifo_chan
    import fsa_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_DEPTH = 32,
    parameter bit HAS_OVF   = 1'b0,
    localparam int AW       = $clog2(MEM_DEPTH),
    localparam int CW       = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [CW-1:0]     depth_i,
    input  logic [CW-1:0]     depth_nxt_i,
    output logic              empty_o,
    output logic              empty_nxt_o,
    output logic              full_nxt_o,
    output logic              full_o,
    output logic              ovf_o
);

    logic [DATA_W-1:0] mem [MEM_DEPTH];
    logic [AW-1:0]     wr_ptr_q;
    logic [AW-1:0]     rd_ptr_q;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     cnt_nxt;
    logic [CW-1:0]     cnt_after_pop;
    logic              pop_ok;
    logic              push_ok;
    logic              push_drop;
    occ_state_t        state_q;
    occ_state_t        state_d;

    function automatic occ_state_t classify(input logic [CW-1:0] c, input logic [CW-1:0] d);
        if (c == '0)
            return OCC_EMPTY;
        else if (c >= d)
            return OCC_FULL;
        else if (c == d - CW'(1))
            return OCC_NEAR;
        else if (c == CW'(1))
            return OCC_LAST;
        else
            return OCC_MID;
    endfunction

    assign pop_ok        = pop_i && !flush_i && (cnt_q != '0);
    assign cnt_after_pop = cnt_q - CW'(pop_ok);
    assign push_ok       = push_i && !flush_i && (cnt_after_pop < depth_i);
    assign push_drop     = push_i && !flush_i && !push_ok;
    assign cnt_nxt       = flush_i ? '0 : (cnt_after_pop + CW'(push_ok));

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wr_ptr_q] <= wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push_ok) wr_ptr_q <= wr_ptr_q + AW'(1);
            if (pop_ok)  rd_ptr_q <= rd_ptr_q + AW'(1);
            cnt_q <= cnt_nxt;
        end
    end

    assign rdata_o = (cnt_q != '0) ? mem[rd_ptr_q] : '0;

    // next-state choice
    always_comb begin
        if (flush_i)
            state_d = OCC_EMPTY;
        else
            state_d = classify(cnt_nxt, depth_nxt_i);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= OCC_EMPTY;
        else
            state_q <= state_d;
    end

    // outputs from state
    always_comb begin
        empty_o     = 1'b0;
        empty_nxt_o = 1'b0;
        full_nxt_o  = 1'b0;
        full_o      = 1'b0;
        unique case (state_q)
            OCC_EMPTY: empty_o     = 1'b1;
            OCC_LAST:  empty_nxt_o = 1'b1;
            OCC_MID:   ;
            OCC_NEAR:  full_nxt_o  = 1'b1;
            OCC_FULL:  full_o      = 1'b1;
            default:   ;
        endcase
    end

    generate
        if (HAS_OVF) begin : g_ovf
            logic ovf_q;
            always_ff @(posedge clk) begin
                if (!rst_n || flush_i)
                    ovf_q <= 1'b0;
                else if (push_drop)
                    ovf_q <= 1'b1;
                else if (pop_i)
                    ovf_q <= 1'b0;
            end
            assign ovf_o = ovf_q;

            // R7: a lost receive word raises the overflow flag
            p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
                push_drop |=> ovf_o);
        end else begin : g_no_ovf
            assign ovf_o = 1'b0;
        end
    endgenerate

    // R10: flush empties the queue on the following edge
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cnt_q == '0 && empty_o));

    // R5: a push at the limit without a pop changes nothing
    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !flush_i && cnt_q >= depth_i) |=> $stable(cnt_q));

    // R8: a pop on an empty queue leaves it empty
    p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !flush_i && cnt_q == '0) |=> (cnt_q == '0));

    // R6: the full state agrees with the counter against the live limit
    p_full_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> (cnt_q >= depth_i));

    p_empty_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty_o == (cnt_q == '0));

    // R11: push and pop together at full keep the count
    p_swap_full_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !flush_i && cnt_q == depth_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/fsa_fifo_pair.sv
module fsa_fifo_pair
    import fsa_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int MEM_DEPTH = 32,
    parameter int FSZ_W     = 6,
    localparam int CW       = $clog2(MEM_DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_fifo_en,
    input  logic              fsz_wr,
    input  logic [FSZ_W-1:0]  fsz_wdata,
    output logic [FSZ_W-1:0]  fsz_q,
    input  logic              tx_push,
    input  logic [DATA_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_rdata,
    input  logic              tx_flush,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_rdata,
    input  logic              rx_flush,
    output logic [STAT_W-1:0] stat_word
);

    logic [CW-1:0] depth;
    logic [CW-1:0] depth_nxt;
    logic tx_e, tx_en, tx_fn, tx_f, tx_ovf_unused;
    logic rx_e, rx_en, rx_fn, rx_f, rx_ovf;

    fsa_depth_sel #(
        .MEM_DEPTH (MEM_DEPTH),
        .FSZ_W     (FSZ_W)
    ) u_depth (
        .clk         (clk),
        .rst_n       (rst_n),
        .big_en_i    (big_fifo_en),
        .fsz_wr_i    (fsz_wr),
        .fsz_wdata_i (fsz_wdata),
        .fsz_o       (fsz_q),
        .depth_o     (depth),
        .depth_nxt_o (depth_nxt)
    );

    fsa_fifo_chan #(
        .DATA_W    (DATA_W),
        .MEM_DEPTH (MEM_DEPTH),
        .HAS_OVF   (1'b0)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (tx_flush),
        .push_i      (tx_push),
        .wdata_i     (tx_wdata),
        .pop_i       (tx_pop),
        .rdata_o     (tx_rdata),
        .depth_i     (depth),
        .depth_nxt_i (depth_nxt),
        .empty_o     (tx_e),
        .empty_nxt_o (tx_en),
        .full_nxt_o  (tx_fn),
        .full_o      (tx_f),
        .ovf_o       (tx_ovf_unused)
    );

    fsa_fifo_chan #(
        .DATA_W    (DATA_W),
        .MEM_DEPTH (MEM_DEPTH),
        .HAS_OVF   (1'b1)
    ) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .flush_i     (rx_flush),
        .push_i      (rx_push),
        .wdata_i     (rx_wdata),
        .pop_i       (rx_pop),
        .rdata_o     (rx_rdata),
        .depth_i     (depth),
        .depth_nxt_i (depth_nxt),
        .empty_o     (rx_e),
        .empty_nxt_o (rx_en),
        .full_nxt_o  (rx_fn),
        .full_o      (rx_f),
        .ovf_o       (rx_ovf)
    );

    always_comb begin
        stat_word                = '0;
        stat_word[STAT_RX_OVF]   = rx_ovf;
        stat_word[STAT_RX_FULL]  = rx_f;
        stat_word[STAT_RX_FNXT]  = rx_fn;
        stat_word[STAT_RX_EMPTY] = rx_e;
        stat_word[STAT_RX_ENXT]  = rx_en;
        stat_word[STAT_TX_FULL]  = tx_f;
        stat_word[STAT_TX_FNXT]  = tx_fn;
        stat_word[STAT_TX_EMPTY] = tx_e;
        stat_word[STAT_TX_ENXT]  = tx_en;
    end

    // R1: both queues are empty straight after reset
    p_reset_empty_r1: assert property (@(posedge clk)
        !rst_n |=> (stat_word == 12'h440));

endmodule

// File: tb/fsa_fifo_pair_tb_top.sv
module fsa_fifo_pair_tb_top;

    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          big_fifo_en = 1'b0;
    logic          fsz_wr = 1'b0;
    logic [5:0]    fsz_wdata = '0;
    logic [5:0]    fsz_q;
    logic          tx_push = 1'b0, tx_pop = 1'b0, tx_flush = 1'b0;
    logic          rx_push = 1'b0, rx_pop = 1'b0, rx_flush = 1'b0;
    logic [DW-1:0] tx_wdata = '0, rx_wdata = '0;
    logic [DW-1:0] tx_rdata, rx_rdata;
    logic [11:0]   stat_word;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fsa_fifo_pair dut_i (
        .clk(clk), .rst_n(rst_n), .big_fifo_en(big_fifo_en),
        .fsz_wr(fsz_wr), .fsz_wdata(fsz_wdata), .fsz_q(fsz_q),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_flush(tx_flush),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop),
        .rx_rdata(rx_rdata), .rx_flush(rx_flush), .stat_word(stat_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        tx_push = 0; tx_pop = 0; tx_flush = 0;
        rx_push = 0; rx_pop = 0; rx_flush = 0;
        fsz_wr = 0;
    endtask

    function automatic int depth_for(input bit big, input int f);
        if (!big) return 4;
        if (f <= 8) return 32;
        if (f <= 16) return 16;
        return 8;
    endfunction

    function automatic logic [11:0] es(input int tc, input int rc, input int d, input bit ovf);
        logic [11:0] s = '0;
        s[2]  = ovf;
        s[4]  = (rc >= d);
        s[5]  = (rc == d - 1);
        s[6]  = (rc == 0);
        s[7]  = (rc == 1);
        s[8]  = (tc >= d);
        s[9]  = (tc == d - 1);
        s[10] = (tc == 0);
        s[11] = (tc == 1);
        return s;
    endfunction

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk("R1 status", 32'(stat_word), 32'h440);
        chk("R1 fsz", 32'(fsz_q), 4);
        chk("R1 tx_rdata", tx_rdata, 0);
        chk("R1 rx_rdata", rx_rdata, 0);

        // R2 R3 R5 R6 R7 R8 R9: sweep enable x every legal frame width
        for (int b = 0; b < 2; b++) begin
            for (int f = 0; f <= 32; f++) begin
                int d;
                int tc;
                int rc;
                bit ov;
                d = depth_for(b[0], f);
                big_fifo_en = b[0];
                fsz_wr = 1; fsz_wdata = 6'(f);
                tx_flush = 1; rx_flush = 1;
                tick();
                chk("R4 fsz stored", 32'(fsz_q), f);
                chk("R10 flushed", 32'(stat_word), 32'(es(0, 0, d, 0)));
                for (int i = 0; i < d + 2; i++) begin
                    tx_push = 1; tx_wdata = 32'hA000_0000 + (f << 8) + i;
                    rx_push = 1; rx_wdata = 32'hB000_0000 + (f << 8) + i;
                    tick();
                    tc = (i + 1 < d) ? i + 1 : d;
                    rc = tc;
                    ov = (i + 1 > d);
                    chk(b ? "R3 R6 R7 fill" : "R2 R6 R7 fill", 32'(stat_word), 32'(es(tc, rc, d, ov)));
                end
                for (int i = 0; i < d + 2; i++) begin
                    chk("R9 R5 tx head", tx_rdata, (i < d) ? 32'hA000_0000 + (f << 8) + i : 0);
                    chk("R9 R8 rx head", rx_rdata, (i < d) ? 32'hB000_0000 + (f << 8) + i : 0);
                    tx_pop = 1; rx_pop = 1;
                    tick();
                    tc = (d - i - 1 > 0) ? d - i - 1 : 0;
                    chk("R6 R8 drain", 32'(stat_word), 32'(es(tc, tc, d, 0)));
                end
            end
        end

        // R4 rejected widths
        big_fifo_en = 1;
        fsz_wr = 1; fsz_wdata = 6'd12; tick();
        chk("R4 accept 12", 32'(fsz_q), 12);
        fsz_wr = 1; fsz_wdata = 6'd45; tick();
        chk("R4 reject 45", 32'(fsz_q), 12);
        fsz_wr = 1; fsz_wdata = 6'd33; tick();
        chk("R4 reject 33", 32'(fsz_q), 12);
        fsz_wr = 1; fsz_wdata = 6'd63; tick();
        chk("R4 reject 63", 32'(fsz_q), 12);

        // R3 run-time shrink: 20 entries at depth 32, then width 16 gives depth 16
        fsz_wr = 1; fsz_wdata = 6'd8; tx_flush = 1; rx_flush = 1; tick();
        for (int i = 0; i < 20; i++) begin
            tx_push = 1; tx_wdata = 32'hC000_0000 + i; tick();
        end
        chk("R3 20 of 32", 32'(stat_word), 32'(es(20, 0, 32, 0)));
        fsz_wr = 1; fsz_wdata = 6'd16; tick();
        chk("R3 shrink full", 32'(stat_word), 32'(es(20, 0, 16, 0)));
        tx_push = 1; tx_wdata = 32'hDEAD_BEEF; tick();
        chk("R5 drop over limit", 32'(stat_word), 32'(es(20, 0, 16, 0)));
        for (int i = 0; i < 5; i++) begin
            chk("R3 R9 head", tx_rdata, 32'hC000_0000 + i);
            tx_pop = 1; tick();
            chk("R3 shrink drain", 32'(stat_word), 32'(es(19 - i, 0, 16, 0)));
        end

        // R9 R11 wrap: depth 4, full, push+pop together 40 times
        big_fifo_en = 0; tx_flush = 1; rx_flush = 1; tick();
        for (int i = 0; i < 4; i++) begin
            tx_push = 1; tx_wdata = 32'h5000_0000 + i;
            rx_push = 1; rx_wdata = 32'h6000_0000 + i;
            tick();
        end
        for (int k = 0; k < 40; k++) begin
            chk("R9 wrap tx head", tx_rdata, 32'h5000_0000 + k);
            chk("R9 wrap rx head", rx_rdata, 32'h6000_0000 + k);
            tx_push = 1; tx_wdata = 32'h5000_0000 + k + 4; tx_pop = 1;
            rx_push = 1; rx_wdata = 32'h6000_0000 + k + 4; rx_pop = 1;
            tick();
            chk("R11 swap stays full", 32'(stat_word), 32'(es(4, 4, 4, 0)));
        end

        // R7 sticky overflow, R10 flush priority and overflow clear
        rx_push = 1; rx_wdata = 32'h1; tick();
        chk("R7 ovf set", 32'(stat_word), 32'(es(4, 4, 4, 1)));
        tick(); tick();
        chk("R7 ovf sticky", 32'(stat_word), 32'(es(4, 4, 4, 1)));
        tx_flush = 1; tx_push = 1; rx_flush = 1; rx_push = 1; rx_pop = 1; tick();
        chk("R10 flush wins", 32'(stat_word), 32'h440);
        chk("R10 tx_rdata", tx_rdata, 0);

        // R8 pop on empty, R7 ovf cleared by a pop on an empty queue
        tx_pop = 1; rx_pop = 1; tick();
        chk("R8 empty pop", 32'(stat_word), 32'h440);
        chk("R8 empty rx_rdata", rx_rdata, 0);
        for (int i = 0; i < 5; i++) begin
            rx_push = 1; rx_wdata = 32'h7000_0000 + i; tick();
        end
        chk("R7 ovf again", 32'(stat_word), 32'(es(0, 4, 4, 1)));
        for (int i = 0; i < 5; i++) begin
            rx_pop = 1; tick();
        end
        chk("R8 empty pop clears ovf", 32'(stat_word), 32'h440);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule